// File: doc/BRIEF.md
# Frame-Paced Isochronous IN Packet Mover

This block feeds an isochronous IN endpoint from system memory. Software points the block at a chain of descriptors. Each descriptor names a packet data area, a packet count and the address of a list of per-packet byte lengths. Every start-of-frame tick, or every software request pulse, moves exactly one packet into a two-slot endpoint buffer. The USB side drains the oldest slot toward the host.

When both slots already hold unsent packets and another packet arrives, the oldest one is overwritten. On an isochronous pipe only timely data matters, so the block keeps the newest packets. After each packet the block writes the progress count back into the descriptor. After the last packet it marks the descriptor retired, raises a completion pulse and follows the next-descriptor link if that link is marked valid.

Software controls the block through a small register port. Endpoint enables and pending requests each have a set view, a clear view and a status view. Memory is word addressed and one word wide. Read data returns one cycle after the read is issued.

Top module: `iso_dma_top`

## Requirements
- R1: After reset, the enable status (register 2) and the request status (register 5) read zero, `usbPktAvail` is low and no memory read is issued.
- R2: Writing ones to register 0 sets those endpoint enable bits. Writing ones to register 1 clears them. Register 2 shows the result, and register 0 reads back zero. An enabled bit stays set until its bit is written to register 1.
- R3: With endpoint `ISO_EP` enabled and a descriptor loaded, one `sofTick` pulse moves exactly one packet. The next packet of the same descriptor waits for a later trigger.
- R4: Writing ones to register 3 sets request bits and writing ones to register 4 clears them. Register 5 shows the pending bits. A request on bit `ISO_EP` acts as one frame trigger and is consumed.
- R5: The descriptor occupies words base+0 (next pointer), base+1 ([15:0] packet count, [16] next valid), base+2 (data start) and base+3 (length list). The length of packet k is read from the list word at list+k. Its data is the next ceil(len/4) words after the previous packet's data. The host sees exactly that length and those words.
- R6: Completed packets are presented oldest first through `usbPktLen` and `usbRdData`. A `usbPktDone` pulse releases the presented packet.
- R7: When both slots hold unsent packets and a new packet is moved, the oldest unsent packet is discarded and the two newest remain, in order.
- R8: After each packet, word base+4 is written with the count of moved packets in [31:16]. After the last packet the same write also sets bit 0 (retired) and status [3:1] = 1 (normal completion), and `dmaDone` pulses for one cycle.
- R9: A trigger that arrives while `ISO_EP` is disabled, or while no descriptor is loaded, issues no memory read, moves no packet and leaves the count word unchanged. A request consumed this way does not fire later.
- R10: A packet of length zero still takes one trigger and delivers a packet of length 0.
- R11: Writing a word address to register 6 loads the descriptor at that address, and register 6 reads the address back. A retired descriptor whose next-valid bit is set is followed by loading the descriptor at its next pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sofTick | input | 1 | Start-of-frame trigger pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| memRdEn | output | 1 | Memory read request |
| memRdAddr | output | ADDR_W | Memory read word address |
| memRdData | input | 32 | Memory read data, one cycle after request |
| memWrEn | output | 1 | Descriptor write-back strobe |
| memWrAddr | output | ADDR_W | Write-back word address |
| memWrData | output | 32 | Write-back data |
| usbPktAvail | output | 1 | A completed packet is presented |
| usbPktLen | output | LEN_W | Byte length of the presented packet |
| usbRdIdx | input | IDX_W | Word index into the presented packet |
| usbRdData | output | 32 | Word of the presented packet |
| usbPktDone | input | 1 | Releases the presented packet |
| dmaDone | output | 1 | Descriptor retired pulse |

## Verification
The bench builds the block with four slot words (16-byte packets), four endpoint bits with the isochronous engine on bit 1, and an 8-bit word address. At this size a 256-word memory model can hold two chained descriptors, their length lists and their data areas. The small slot depth makes multi-word transfers, zero-length packets and the full-buffer overwrite of the oldest packet all reachable within a few frames. The scoreboard predicts every packet from the bench's own memory image and checks the descriptor write-backs word by word.

// File: rtl/iso_dma_pkg.sv
package iso_dma_pkg;

  // register indices on the software port
  localparam logic [2:0] REG_EN_SET    = 3'd0;
  localparam logic [2:0] REG_EN_CLR    = 3'd1;
  localparam logic [2:0] REG_EN_STAT   = 3'd2;
  localparam logic [2:0] REG_REQ_SET   = 3'd3;
  localparam logic [2:0] REG_REQ_CLR   = 3'd4;
  localparam logic [2:0] REG_REQ_STAT  = 3'd5;
  localparam logic [2:0] REG_DESC_HEAD = 3'd6;

  localparam logic [2:0] STATUS_NORMAL = 3'd1;

  typedef enum logic [1:0] {SEL_DESC, SEL_LEN, SEL_DATA} memSel_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LD0, ST_LD1, ST_LD2, ST_LD3, ST_LD4,
    ST_LEN_RD, ST_LEN_WAIT, ST_MOVE, ST_PKT_END
  } dmaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       startHead;
    logic       startNext;
    logic       ldNext;
    logic       ldCtl;
    logic       ldBuf;
    logic       ldList;
    logic       arm;
    logic       lenCapture;
    logic       issueData;
    logic       commitPkt;
    logic       retire;
    logic       drop;
    logic       rdEn;
    memSel_t    memSel;
    logic [1:0] descOfs;
  } dpCtrl_t;

endpackage

// File: rtl/iso_dma_ctrl.sv
module iso_dma_ctrl
  import iso_dma_pkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int ISO_EP = 3,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sofTick,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              descValid,
  input  logic              nextValid,
  input  logic              lastPkt,
  input  logic              lenZero,
  input  logic              lastIssue,
  output logic [ADDR_W-1:0] headAddr,
  output logic [NUM_EP-1:0] enStat,
  output dpCtrl_t           dp,
  output logic              dmaDone
);

  dmaState_t         state, nextState;
  logic [NUM_EP-1:0] reqStat;
  logic              headPending;
  logic              consumeReq;
  logic [NUM_EP-1:0] wrBits, enSetV, enClrV, reqSetV, reqClrV, consumeV;

  assign wrBits   = regWrData[NUM_EP-1:0];
  assign enSetV   = (regWrEn && regAddr == REG_EN_SET)  ? wrBits : '0;
  assign enClrV   = (regWrEn && regAddr == REG_EN_CLR)  ? wrBits : '0;
  assign reqSetV  = (regWrEn && regAddr == REG_REQ_SET) ? wrBits : '0;
  assign reqClrV  = (regWrEn && regAddr == REG_REQ_CLR) ? wrBits : '0;
  assign consumeV = consumeReq ? (NUM_EP'(1) << ISO_EP) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      enStat      <= '0;
      reqStat     <= '0;
      headPending <= 1'b0;
      headAddr    <= '0;
    end else begin
      state   <= nextState;
      enStat  <= (enStat | enSetV) & ~enClrV;
      reqStat <= (reqStat & ~reqClrV & ~consumeV) | reqSetV;
      if (regWrEn && regAddr == REG_DESC_HEAD) begin
        headAddr    <= regWrData[ADDR_W-1:0];
        headPending <= 1'b1;
      end else if (dp.startHead) begin
        headPending <= 1'b0;
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_EN_STAT:   regRdData = 32'(enStat);
      REG_REQ_STAT:  regRdData = 32'(reqStat);
      REG_DESC_HEAD: regRdData = 32'(headAddr);
      default:       regRdData = '0;
    endcase
  end

  always_comb begin
    dp         = '0;
    dp.memSel  = SEL_DESC;
    nextState  = state;
    consumeReq = 1'b0;
    dmaDone    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (headPending) begin
          dp.startHead = 1'b1;
          nextState    = ST_LD0;
        end else if (sofTick || reqStat[ISO_EP]) begin
          consumeReq = reqStat[ISO_EP];
          if (enStat[ISO_EP] && descValid) nextState = ST_LEN_RD;
        end
      end
      ST_LD0: begin dp.rdEn = 1'b1; dp.descOfs = 2'd0; nextState = ST_LD1; end
      ST_LD1: begin dp.rdEn = 1'b1; dp.descOfs = 2'd1; dp.ldNext = 1'b1; nextState = ST_LD2; end
      ST_LD2: begin dp.rdEn = 1'b1; dp.descOfs = 2'd2; dp.ldCtl  = 1'b1; nextState = ST_LD3; end
      ST_LD3: begin dp.rdEn = 1'b1; dp.descOfs = 2'd3; dp.ldBuf  = 1'b1; nextState = ST_LD4; end
      ST_LD4: begin dp.ldList = 1'b1; dp.arm = 1'b1; nextState = ST_IDLE; end
      ST_LEN_RD: begin
        dp.rdEn   = 1'b1;
        dp.memSel = SEL_LEN;
        nextState = ST_LEN_WAIT;
      end
      ST_LEN_WAIT: begin
        dp.lenCapture = 1'b1;
        nextState     = lenZero ? ST_PKT_END : ST_MOVE;
      end
      ST_MOVE: begin
        dp.rdEn      = 1'b1;
        dp.memSel    = SEL_DATA;
        dp.issueData = 1'b1;
        if (lastIssue) nextState = ST_PKT_END;
      end
      ST_PKT_END: begin
        dp.commitPkt = 1'b1;
        nextState    = ST_IDLE;
        if (lastPkt) begin
          dp.retire = 1'b1;
          dmaDone   = 1'b1;
          if (nextValid) begin
            dp.startNext = 1'b1;
            nextState    = ST_LD0;
          end else begin
            dp.drop = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/iso_dma_datapath.sv
module iso_dma_datapath
  import iso_dma_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SLOT_WORDS = 16,
  localparam int IDX_W     = $clog2(SLOT_WORDS),
  localparam int LEN_W     = $clog2(SLOT_WORDS * 4 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dp,
  input  logic [ADDR_W-1:0] headAddr,
  input  logic [31:0]       memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic              descValid,
  output logic              nextValid,
  output logic              lastPkt,
  output logic              lenZero,
  output logic              lastIssue,
  input  logic              usbPktDone,
  input  logic [IDX_W-1:0]  usbRdIdx,
  output logic              usbPktAvail,
  output logic [LEN_W-1:0]  usbPktLen,
  output logic [31:0]       usbRdData,
  output logic [1:0]        slotCnt
);

  localparam int CNT_W      = 16;
  localparam int WCNT_W     = IDX_W + 1;
  localparam int SLOT_BYTES = SLOT_WORDS * 4;

  logic [ADDR_W-1:0] descBase, nextPtr, bufPtr, listAddr;
  logic [CNT_W-1:0]  pktTotal, presentCnt, presentInc;
  logic [LEN_W-1:0]  pktLen, lenClamp;
  logic [WCNT_W-1:0] pktWords, wordsCalc, dataIdx;
  logic [15:0]       lenRaw;
  logic              capValid;
  logic [IDX_W-1:0]  capIdx;

  // slot ring: head, count of finished packets, fill target
  logic       hd, tgt, popEff, dropOld, hdNext;
  logic [1:0] cntAfterPop;
  logic [31:0]      slotWord [2];
  logic [LEN_W-1:0] slotLen  [2];

  assign lenRaw     = memRdData[15:0];
  assign lenClamp   = (lenRaw > 16'(SLOT_BYTES)) ? LEN_W'(SLOT_BYTES) : lenRaw[LEN_W-1:0];
  assign wordsCalc  = WCNT_W'(({1'b0, lenClamp} + (LEN_W + 1)'(3)) >> 2);
  assign lenZero    = (lenRaw == 16'd0);
  assign lastIssue  = (dataIdx == pktWords - WCNT_W'(1));
  assign presentInc = presentCnt + CNT_W'(1);
  assign lastPkt    = (presentInc >= pktTotal);

  always_comb begin
    memRdEn = dp.rdEn;
    case (dp.memSel)
      SEL_LEN:  memRdAddr = listAddr + ADDR_W'(presentCnt);
      SEL_DATA: memRdAddr = bufPtr + ADDR_W'(dataIdx);
      default:  memRdAddr = descBase + ADDR_W'(dp.descOfs);
    endcase
  end

  assign memWrEn   = dp.commitPkt;
  assign memWrAddr = descBase + ADDR_W'(4);
  assign memWrData = {presentInc, 12'd0, dp.retire ? STATUS_NORMAL : 3'd0, dp.retire};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descBase   <= '0;
      nextPtr    <= '0;
      nextValid  <= 1'b0;
      pktTotal   <= '0;
      bufPtr     <= '0;
      listAddr   <= '0;
      presentCnt <= '0;
      descValid  <= 1'b0;
      pktLen     <= '0;
      pktWords   <= '0;
      dataIdx    <= '0;
      capValid   <= 1'b0;
      capIdx     <= '0;
    end else begin
      capValid <= dp.issueData;
      capIdx   <= dataIdx[IDX_W-1:0];
      if (dp.startHead) begin
        descBase  <= headAddr;
        descValid <= 1'b0;
      end
      if (dp.startNext) begin
        descBase  <= nextPtr;
        descValid <= 1'b0;
      end
      if (dp.drop) descValid <= 1'b0;
      if (dp.ldNext) nextPtr <= memRdData[ADDR_W-1:0];
      if (dp.ldCtl) begin
        pktTotal  <= memRdData[15:0];
        nextValid <= memRdData[16];
      end
      if (dp.ldBuf)  bufPtr   <= memRdData[ADDR_W-1:0];
      if (dp.ldList) listAddr <= memRdData[ADDR_W-1:0];
      if (dp.arm) begin
        descValid  <= 1'b1;
        presentCnt <= '0;
      end
      if (dp.lenCapture) begin
        pktLen   <= lenClamp;
        pktWords <= wordsCalc;
        dataIdx  <= '0;
      end
      if (dp.issueData) dataIdx <= dataIdx + WCNT_W'(1);
      if (dp.commitPkt) begin
        presentCnt <= presentInc;
        bufPtr     <= bufPtr + ADDR_W'(pktWords);
      end
    end
  end

  // ring bookkeeping; a reservation into a full ring evicts the head
  assign popEff      = usbPktDone && (slotCnt != 2'd0);
  assign cntAfterPop = slotCnt - 2'(popEff);
  assign dropOld     = dp.lenCapture && (cntAfterPop == 2'd2);
  assign hdNext      = hd ^ popEff ^ dropOld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hd      <= 1'b0;
      tgt     <= 1'b0;
      slotCnt <= '0;
    end else begin
      hd      <= hdNext;
      slotCnt <= cntAfterPop - 2'(dropOld) + 2'(dp.commitPkt);
      if (dp.lenCapture) tgt <= hdNext ^ (dropOld ? 1'b1 : cntAfterPop[0]);
    end
  end

  for (genvar s = 0; s < 2; s++) begin : gSlot
    logic [31:0]      words [SLOT_WORDS];
    logic [LEN_W-1:0] lenQ;
    always_ff @(posedge clk) begin
      if (capValid && tgt == 1'(s)) words[capIdx] <= memRdData;
      if (dp.commitPkt && tgt == 1'(s)) lenQ <= pktLen;
    end
    assign slotWord[s] = words[usbRdIdx];
    assign slotLen[s]  = lenQ;
  end

  assign usbPktAvail = (slotCnt != 2'd0);
  assign usbPktLen   = slotLen[hd];
  assign usbRdData   = slotWord[hd];

endmodule

// File: rtl/iso_dma_top.sv
module iso_dma_top
  import iso_dma_pkg::*;
#(
  parameter int NUM_EP     = 8,
  parameter int ISO_EP     = 3,
  parameter int ADDR_W     = 16,
  parameter int SLOT_WORDS = 16,
  localparam int IDX_W     = $clog2(SLOT_WORDS),
  localparam int LEN_W     = $clog2(SLOT_WORDS * 4 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sofTick,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [31:0]       memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic              usbPktAvail,
  output logic [LEN_W-1:0]  usbPktLen,
  input  logic [IDX_W-1:0]  usbRdIdx,
  output logic [31:0]       usbRdData,
  input  logic              usbPktDone,
  output logic              dmaDone
);

  dpCtrl_t           dpBus;
  logic [ADDR_W-1:0] headAddr;
  logic [NUM_EP-1:0] enStat;
  logic [1:0]        slotCnt;
  logic descValid, nextValid, lastPkt, lenZero, lastIssue;

  iso_dma_ctrl #(.NUM_EP(NUM_EP), .ISO_EP(ISO_EP), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sofTick(sofTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .descValid(descValid), .nextValid(nextValid), .lastPkt(lastPkt),
    .lenZero(lenZero), .lastIssue(lastIssue),
    .headAddr(headAddr), .enStat(enStat), .dp(dpBus), .dmaDone(dmaDone)
  );

  iso_dma_datapath #(.ADDR_W(ADDR_W), .SLOT_WORDS(SLOT_WORDS)) uDp (
    .clk(clk), .rstN(rstN), .dp(dpBus), .headAddr(headAddr),
    .memRdData(memRdData), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .descValid(descValid), .nextValid(nextValid), .lastPkt(lastPkt),
    .lenZero(lenZero), .lastIssue(lastIssue),
    .usbPktDone(usbPktDone), .usbRdIdx(usbRdIdx), .usbPktAvail(usbPktAvail),
    .usbPktLen(usbPktLen), .usbRdData(usbRdData), .slotCnt(slotCnt)
  );

endmodule

// File: rtl/iso_dma_checker.sv
module iso_dma_checker
  import iso_dma_pkg::*;
#(
  parameter int NUM_EP = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic [NUM_EP-1:0] enStat,
  input logic [1:0]        slotCnt,
  input logic              dmaDone,
  input logic              memWrEn,
  input logic [31:0]       memWrData
);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |=> !dmaDone);

  assert_done_retires_R8: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |-> (memWrEn && memWrData[0] && memWrData[3:1] == STATUS_NORMAL));

  assert_retire_has_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && memWrData[0]) |-> dmaDone);

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == REG_EN_CLR) |=> (($past(enStat) & ~enStat) == '0));

  assert_slot_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt <= 2'd2);

endmodule

bind iso_dma_top iso_dma_checker #(.NUM_EP(NUM_EP)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .enStat(enStat), .slotCnt(slotCnt), .dmaDone(dmaDone),
  .memWrEn(memWrEn), .memWrData(memWrData)
);

// File: tb/sim_iso_dma_top.sv
module sim_iso_dma_top;

  localparam int NUM_EP     = 4;
  localparam int ISO_EP     = 1;
  localparam int ADDR_W     = 8;
  localparam int SLOT_WORDS = 4;
  localparam int IDX_W      = $clog2(SLOT_WORDS);
  localparam int LEN_W      = $clog2(SLOT_WORDS * 4 + 1);
  localparam logic [31:0] ISO_BIT = 32'(1) << ISO_EP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sofTick = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memRdEn, memWrEn;
  logic [ADDR_W-1:0] memRdAddr, memWrAddr;
  logic [31:0] memRdData, memWrData;
  logic usbPktAvail;
  logic [LEN_W-1:0] usbPktLen;
  logic [IDX_W-1:0] usbRdIdx = '0;
  logic [31:0] usbRdData;
  logic usbPktDone = 1'b0;
  logic dmaDone;

  int checks = 0;
  int errors = 0;
  int rdCnt = 0;
  int doneCnt = 0;
  int pktsSeen = 0;
  bit monOn = 1'b0;

  int          expLen[$];
  logic [31:0] expWord[$];
  logic [31:0] mem [256];

  always #4 clk = ~clk;

  iso_dma_top #(.NUM_EP(NUM_EP), .ISO_EP(ISO_EP), .ADDR_W(ADDR_W), .SLOT_WORDS(SLOT_WORDS)) u0 (
    .clk(clk), .rstN(rstN), .sofTick(sofTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .usbPktAvail(usbPktAvail), .usbPktLen(usbPktLen), .usbRdIdx(usbRdIdx),
    .usbRdData(usbRdData), .usbPktDone(usbPktDone), .dmaDone(dmaDone)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= mem[memRdAddr];
      rdCnt <= rdCnt + 1;
    end
    if (memWrEn) mem[memWrAddr] <= memWrData;
    if (rstN && dmaDone) doneCnt <= doneCnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic pulseSof();
    @(negedge clk); sofTick = 1'b1;
    @(negedge clk); sofTick = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic expectPkt(input int len, input int bufAddr);
    expLen.push_back(len);
    for (int i = 0; i < (len + 3) / 4; i++) expWord.push_back(mem[bufAddr + i]);
  endtask

  // monitor side: drains the presented packet and compares it
  initial begin
    forever begin
      @(negedge clk);
      if (monOn && rstN && usbPktAvail) begin
        int eL;
        if (expLen.size() == 0) begin
          check(1'b0, "R6 unexpected packet", 32'(usbPktLen), 0);
        end else begin
          eL = expLen.pop_front();
          check(32'(usbPktLen) == 32'(eL), "R5 packet length", 32'(usbPktLen), 32'(eL));
          for (int i = 0; i < (eL + 3) / 4; i++) begin
            logic [31:0] w;
            usbRdIdx = IDX_W'(i);
            #1;
            w = expWord.pop_front();
            check(usbRdData == w, "R5 packet word", usbRdData, w);
          end
        end
        pktsSeen++;
        usbPktDone = 1'b1;
        @(negedge clk);
        usbPktDone = 1'b0;
      end
    end
  end

  task automatic runTests();
    logic [31:0] v;
    int r0, d0, p0;

    for (int a = 0; a < 256; a++) mem[a] = 32'hD000_0000 | 32'(a);
    // descriptor A at 0x10, chained to B
    mem[8'h10] = 32'h20; mem[8'h11] = 32'h0001_0003; mem[8'h12] = 32'h40;
    mem[8'h13] = 32'h30; mem[8'h14] = 32'h0;
    mem[8'h30] = 32'd8;  mem[8'h31] = 32'd0;  mem[8'h32] = 32'd13;
    // descriptor B at 0x20, end of chain
    mem[8'h20] = 32'h0;  mem[8'h21] = 32'h0000_0003; mem[8'h22] = 32'h60;
    mem[8'h23] = 32'h38; mem[8'h24] = 32'h0;
    mem[8'h38] = 32'd4;  mem[8'h39] = 32'd12; mem[8'h3A] = 32'd16;

    waitCyc(5);
    rstN = 1'b1;

    // R1 reset state
    regRead(3'd2, v); check(v == 0, "R1 enable status", v, 0);
    regRead(3'd5, v); check(v == 0, "R1 request status", v, 0);
    check(!usbPktAvail, "R1 no packet", 32'(usbPktAvail), 0);
    check(!memRdEn, "R1 no read", 32'(memRdEn), 0);

    // R2 enable set / clear / status
    regWrite(3'd0, 32'hA);
    regRead(3'd2, v); check(v == 32'hA, "R2 set", v, 32'hA);
    regRead(3'd0, v); check(v == 0, "R2 set view reads zero", v, 0);
    regWrite(3'd1, 32'h2);
    regRead(3'd2, v); check(v == 32'h8, "R2 clear one bit", v, 32'h8);
    regWrite(3'd1, 32'h8);
    regWrite(3'd0, ISO_BIT);
    regRead(3'd2, v); check(v == ISO_BIT, "R2 iso enabled", v, ISO_BIT);

    // R4 request status view on a non-engine bit
    regWrite(3'd3, 32'h1);
    regRead(3'd5, v); check(v == 32'h1, "R4 request pending", v, 32'h1);
    regWrite(3'd4, 32'h1);
    regRead(3'd5, v); check(v == 0, "R4 request cleared", v, 0);

    // R9 triggers with no descriptor
    r0 = rdCnt;
    pulseSof();
    regWrite(3'd3, ISO_BIT);
    waitCyc(10);
    check(rdCnt == r0, "R9 no read without descriptor", 32'(rdCnt), 32'(r0));
    regRead(3'd5, v); check(v == 0, "R9 request consumed", v, 0);

    // R11 load descriptor A
    regWrite(3'd6, 32'h10);
    waitCyc(10);
    regRead(3'd6, v); check(v == 32'h10, "R11 head readback", v, 32'h10);
    check(!usbPktAvail, "R9 stale request did not fire", 32'(usbPktAvail), 0);

    // R9 disabled endpoint ignores frame tick
    regWrite(3'd1, ISO_BIT);
    r0 = rdCnt;
    pulseSof();
    waitCyc(10);
    check(rdCnt == r0, "R9 no read while disabled", 32'(rdCnt), 32'(r0));
    check(mem[8'h14] == 0, "R9 count untouched", mem[8'h14], 0);
    check(!usbPktAvail, "R9 no packet while disabled", 32'(usbPktAvail), 0);
    regWrite(3'd0, ISO_BIT);

    monOn = 1'b1;
    // R3 one frame tick, one packet
    expectPkt(8, 8'h40);
    pulseSof();
    waitCyc(20);
    check(expLen.size() == 0, "R3 packet delivered", 32'(expLen.size()), 0);
    check(mem[8'h14] == 32'h0001_0000, "R8 progress writeback", mem[8'h14], 32'h0001_0000);
    waitCyc(20);
    check(pktsSeen == 1, "R3 no second packet without trigger", 32'(pktsSeen), 1);
    check(mem[8'h14][31:16] == 16'd1, "R3 count held", 32'(mem[8'h14][31:16]), 1);

    // R4 software request, R10 zero-length packet
    expectPkt(0, 8'h42);
    regWrite(3'd3, ISO_BIT);
    waitCyc(20);
    check(pktsSeen == 2, "R10 empty packet delivered", 32'(pktsSeen), 2);
    check(mem[8'h14] == 32'h0002_0000, "R4 request moved one packet", mem[8'h14], 32'h0002_0000);

    // R8 last packet retires descriptor A
    d0 = doneCnt;
    expectPkt(13, 8'h42);
    pulseSof();
    waitCyc(30);
    check(doneCnt == d0 + 1, "R8 single done pulse", 32'(doneCnt), 32'(d0 + 1));
    check(mem[8'h14] == 32'h0003_0003, "R8 retired writeback", mem[8'h14], 32'h0003_0003);
    check(expLen.size() == 0, "R5 odd length packet", 32'(expLen.size()), 0);

    // R6/R7 fill both slots then overflow, on chained descriptor B
    monOn = 1'b0;
    waitCyc(2);
    pulseSof();
    waitCyc(20);
    check(usbPktAvail && usbPktLen == LEN_W'(4), "R6 first packet presented", 32'(usbPktLen), 4);
    pulseSof();
    waitCyc(20);
    check(usbPktLen == LEN_W'(4), "R6 oldest stays in front", 32'(usbPktLen), 4);
    pulseSof();
    waitCyc(30);
    check(usbPktLen == LEN_W'(12), "R7 oldest overwritten", 32'(usbPktLen), 12);
    check(mem[8'h24] == 32'h0003_0003, "R11 chained descriptor retired", mem[8'h24], 32'h0003_0003);
    p0 = pktsSeen;
    expectPkt(12, 8'h61);
    expectPkt(16, 8'h64);
    monOn = 1'b1;
    waitCyc(30);
    check(pktsSeen == p0 + 2, "R7 two newest remain", 32'(pktsSeen), 32'(p0 + 2));
    check(expLen.size() == 0, "R7 order of survivors", 32'(expLen.size()), 0);
    check(!usbPktAvail, "R6 ring drained", 32'(usbPktAvail), 0);

    // R9 no descriptor after end of chain
    r0 = rdCnt;
    pulseSof();
    waitCyc(20);
    check(rdCnt == r0, "R9 no read after chain end", 32'(rdCnt), 32'(r0));
    check(pktsSeen == p0 + 2, "R9 no packet after chain end", 32'(pktsSeen), 32'(p0 + 2));
    regRead(3'd2, v); check(v == ISO_BIT, "R2 enable persisted", v, ISO_BIT);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule